// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a synthesizable model of a 36-bit synchronous static RAM with a registered read path. Every synchronous input is captured on the rising clock edge. A captured read is looked up in the array and placed in an output register one edge later. A burst starts with one address and can run through four words. The first word arrives one edge after the load and each further word one edge after that, which gives a 3-1-1-1 pattern at the pins.

The word is split into four 9-bit lanes: 8 data bits and one parity bit each. A lane-select write stores only the chosen lanes. An all-lanes write stores the whole word and overrides the lane controls. The device is selected only when its three enables are all at their active levels on a load cycle. A load cycle that finds it unselected ends any burst and turns the data outputs off right after that edge. This turn-off is one stage earlier than a read would drive them.

The output enable and the sleep input both act without the clock. While sleep is high, accesses are blocked and the array keeps its contents. The bidirectional data bus is split into an input, an output and a drive-enable. The array is small and is set by a parameter.

Top module: `sync_burst_sram`

## Requirements
- R1: A load cycle (either load strobe low) starts an access only when ce1N=0, ce2=1 and ce3N=0. Otherwise nothing is written and no data is returned.
- R2: A read captured at edge e, with no deselect captured at edge e+1, drives the word on dataOut with dataOe=1 after edge e+1. This assumes oeN=0 and sleep=0.
- R3: A deselecting load captured at edge e forces dataOe=0 right after edge e. This holds even when a read was captured at edge e-1.
- R4: With globalWrN=1 and byteWrN=0, lane i (bits 9i+8 down to 9i) is written only when laneSelN[i]=0. The other lanes keep their old contents.
- R5: With globalWrN=0 on a selected access that is not forced to a read, all four lanes are written, whatever byteWrN and laneSelN are.
- R6: An access with globalWrN=1 and either byteWrN=1 or laneSelN=4'b1111 writes nothing and is a read.
- R7: A load through procLoadN=0 is always a read: the write controls are ignored on that cycle. procLoadN has priority over ctrlLoadN.
- R8: On a cycle with neither strobe low during an active burst, advanceN=0 steps a 2-bit counter from 0. The low two address bits then come from the counter. With seqLinear=1 they are base+count mod 4. With seqLinear=0 they are base XOR count.
- R9: On a continue cycle with advanceN=1, the same address is accessed again.
- R10: oeN=1 forces dataOe=0 at once, without a clock edge. Returning it to 0 restores the drive at once.
- R11: sleep=1 forces dataOe=0 at once. An edge with sleep=1 writes nothing and ends the burst. Stored contents are kept.
- R12: While rstN=0 at an edge, the pipeline and burst state clear, so dataOe=0 afterwards.
- R13: dataOe=1 exactly when oeN=0, sleep=0, a read was captured one edge earlier and the last edge captured no deselect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Synchronous active-low reset of pipeline and burst state |
| sleep | input | 1 | Asynchronous low-power request, active high |
| oeN | input | 1 | Asynchronous output enable, active low |
| addrIn | input | ADDR_W | Word address, captured on load cycles |
| ce1N | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3N | input | 1 | Chip enable, active low |
| procLoadN | input | 1 | Load strobe that always reads, active low |
| ctrlLoadN | input | 1 | Load strobe honouring write controls, active low |
| advanceN | input | 1 | Burst counter step on continue cycles, active low |
| seqLinear | input | 1 | Burst order: 1 linear, 0 interleaved |
| globalWrN | input | 1 | All-lanes write, active low |
| byteWrN | input | 1 | Lane-select write enable, active low |
| laneSelN | input | 4 | Per-lane write selects, active low |
| dataIn | input | 4*LANE_W | Write data |
| dataOut | output | 4*LANE_W | Read data from the output register |
| dataOe | output | 1 | Drive enable for dataOut |

## Verification
Writes land at the capturing edge. A read word appears one edge after its capture, and a deselect removes the drive right after its own edge. Oe and sleep act within the same cycle. The bench keeps a reference model that steps once per edge. It drives inputs at the falling edge and compares dataOe and dataOut at the next falling edge against the model's post-edge state. Directed sequences name the expected word for each burst beat, and the asynchronous inputs are probed mid-cycle with no clock edge in between.

// File: rtl/sram_pkg.sv
package sram_pkg;
  localparam int unsigned LANES = 4;

  typedef struct packed {
    logic [LANES-1:0] wrMask;   // lanes to store this edge
    logic             rdEn;     // read captured this edge
    logic             deselCap; // deselecting load captured this edge
  } memCmd_t;
endpackage

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_pkg::*;
#(
  parameter int unsigned ADDR_W  = 6,
  parameter int unsigned BURST_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sleep,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              ce1N,
  input  logic              ce2,
  input  logic              ce3N,
  input  logic              procLoadN,
  input  logic              ctrlLoadN,
  input  logic              advanceN,
  input  logic              seqLinear,
  input  logic              globalWrN,
  input  logic              byteWrN,
  input  logic [LANES-1:0]  laneSelN,
  output memCmd_t           cmd,
  output logic [ADDR_W-1:0] accAddr
);
  logic               activeQ;
  logic [ADDR_W-1:0]  baseQ;
  logic [BURST_W-1:0] cntQ;

  logic               loadCyc;
  logic               selNow;
  logic               access;
  logic               forceRead;
  logic [LANES-1:0]   laneMask;
  logic [BURST_W-1:0] cntNext;
  logic [ADDR_W-1:0]  baseSel;
  logic [BURST_W-1:0] lowBits;

  always_comb begin
    loadCyc   = !procLoadN || !ctrlLoadN;
    selNow    = !ce1N && ce2 && !ce3N;
    forceRead = !procLoadN;
    if (!globalWrN)    laneMask = '1;
    else if (!byteWrN) laneMask = ~laneSelN;
    else               laneMask = '0;
    cntNext = loadCyc ? '0 : cntQ + {{(BURST_W-1){1'b0}}, !advanceN};
    baseSel = loadCyc ? addrIn : baseQ;
    lowBits = seqLinear ? (baseSel[BURST_W-1:0] + cntNext)
                        : (baseSel[BURST_W-1:0] ^ cntNext);
    accAddr = {baseSel[ADDR_W-1:BURST_W], lowBits};
    access  = !sleep && (loadCyc ? selNow : activeQ);

    cmd.wrMask   = (access && !forceRead) ? laneMask : '0;
    cmd.rdEn     = access && (forceRead || laneMask == '0);
    cmd.deselCap = !sleep && loadCyc && !selNow;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeQ <= 1'b0;
      baseQ   <= '0;
      cntQ    <= '0;
    end else if (sleep) begin
      activeQ <= 1'b0;
    end else if (loadCyc) begin
      activeQ <= selNow;
      baseQ   <= addrIn;
      cntQ    <= '0;
    end else if (activeQ) begin
      cntQ    <= cntNext;
    end
  end
endmodule

// File: rtl/sram_datapath.sv
module sram_datapath
  import sram_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  memCmd_t                 cmd,
  input  logic [ADDR_W-1:0]       accAddr,
  input  logic [LANES*LANE_W-1:0] dataIn,
  output logic [LANES*LANE_W-1:0] rdData,
  output logic                    rdValid,
  output logic                    deselQ
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic              rdPendQ;
  logic [ADDR_W-1:0] rdAddrQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPendQ <= 1'b0;
      rdValid <= 1'b0;
      deselQ  <= 1'b0;
    end else begin
      rdPendQ <= cmd.rdEn;
      rdValid <= rdPendQ;
      deselQ  <= cmd.deselCap;
    end
  end

  always_ff @(posedge clk) begin
    if (cmd.rdEn) rdAddrQ <= accAddr;
  end

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [LANE_W-1:0] laneMem [DEPTH];
    logic [LANE_W-1:0] outQ;

    always_ff @(posedge clk) begin
      if (cmd.wrMask[g]) laneMem[accAddr] <= dataIn[g*LANE_W +: LANE_W];
      if (rdPendQ)       outQ <= laneMem[rdAddrQ];
    end

    assign rdData[g*LANE_W +: LANE_W] = outQ;
  end
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
  import sram_pkg::*;
#(
  parameter int unsigned ADDR_W  = 6,
  parameter int unsigned LANE_W  = 9,
  parameter int unsigned BURST_W = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    sleep,
  input  logic                    oeN,
  input  logic [ADDR_W-1:0]       addrIn,
  input  logic                    ce1N,
  input  logic                    ce2,
  input  logic                    ce3N,
  input  logic                    procLoadN,
  input  logic                    ctrlLoadN,
  input  logic                    advanceN,
  input  logic                    seqLinear,
  input  logic                    globalWrN,
  input  logic                    byteWrN,
  input  logic [LANES-1:0]        laneSelN,
  input  logic [LANES*LANE_W-1:0] dataIn,
  output logic [LANES*LANE_W-1:0] dataOut,
  output logic                    dataOe
);
  memCmd_t           cmd;
  logic [ADDR_W-1:0] accAddr;
  logic              rdValid;
  logic              deselQ;

  sram_ctrl #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .sleep(sleep), .addrIn(addrIn),
    .ce1N(ce1N), .ce2(ce2), .ce3N(ce3N),
    .procLoadN(procLoadN), .ctrlLoadN(ctrlLoadN), .advanceN(advanceN),
    .seqLinear(seqLinear), .globalWrN(globalWrN), .byteWrN(byteWrN),
    .laneSelN(laneSelN), .cmd(cmd), .accAddr(accAddr)
  );

  sram_datapath #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .accAddr(accAddr),
    .dataIn(dataIn), .rdData(dataOut), .rdValid(rdValid), .deselQ(deselQ)
  );

  assign dataOe = !oeN && !sleep && rdValid && !deselQ;
endmodule

// File: rtl/sram_pipe_chk.sv
module sram_pipe_chk
  import sram_pkg::*;
(
  input logic    clk,
  input logic    rstN,
  input logic    sleep,
  input logic    oeN,
  input logic    procLoadN,
  input logic    ctrlLoadN,
  input logic    ce1N,
  input logic    ce2,
  input logic    ce3N,
  input logic    globalWrN,
  input memCmd_t cmd,
  input logic    dataOe
);
  logic selNow, loadNow, deselNow, procReadNow;
  assign selNow      = !ce1N && ce2 && !ce3N;
  assign loadNow     = !procLoadN || !ctrlLoadN;
  assign deselNow    = !sleep && loadNow && !selNow;
  assign procReadNow = !sleep && !procLoadN && selNow;

  // R3
  desel_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    deselNow |=> !dataOe);

  // R13
  no_stray_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataOe |-> $past(cmd.rdEn, 2));

  // R2
  read_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!oeN && !sleep && $past(rstN) && $past(rstN, 2) &&
     $past(procReadNow, 2) && !$past(deselNow)) |-> dataOe);

  // R7
  proc_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!procLoadN && !sleep) |-> (cmd.wrMask == '0));

  // R5
  global_all_lanes_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!sleep && procLoadN && !ctrlLoadN && selNow && !globalWrN) |-> (&cmd.wrMask));

  // R11
  sleep_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    sleep |-> (cmd.wrMask == '0 && !cmd.rdEn));
endmodule

bind sync_burst_sram sram_pipe_chk u_chk (
  .clk(clk), .rstN(rstN), .sleep(sleep), .oeN(oeN),
  .procLoadN(procLoadN), .ctrlLoadN(ctrlLoadN),
  .ce1N(ce1N), .ce2(ce2), .ce3N(ce3N), .globalWrN(globalWrN),
  .cmd(cmd), .dataOe(dataOe)
);

// File: tb/sync_burst_sram_tb.sv
`timescale 1ns/1ps
module sync_burst_sram_tb;
  localparam int ADDR_W = 6;
  localparam int LANE_W = 9;
  localparam int LANES  = 4;
  localparam int WORD_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rstN, sleep, oeN, ce1N, ce2, ce3N;
  logic procLoadN, ctrlLoadN, advanceN, seqLinear, globalWrN, byteWrN;
  logic [ADDR_W-1:0] addrIn;
  logic [LANES-1:0]  laneSelN;
  logic [WORD_W-1:0] dataIn, dataOut;
  logic dataOe;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  sync_burst_sram #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_dut (
    .clk(clk), .rstN(rstN), .sleep(sleep), .oeN(oeN), .addrIn(addrIn),
    .ce1N(ce1N), .ce2(ce2), .ce3N(ce3N), .procLoadN(procLoadN),
    .ctrlLoadN(ctrlLoadN), .advanceN(advanceN), .seqLinear(seqLinear),
    .globalWrN(globalWrN), .byteWrN(byteWrN), .laneSelN(laneSelN),
    .dataIn(dataIn), .dataOut(dataOut), .dataOe(dataOe)
  );

  // reference model state
  bit [WORD_W-1:0] mMem [DEPTH];
  bit              mActive, mPend, mValid, mDesel;
  bit [ADDR_W-1:0] mBase, mPendAddr;
  bit [1:0]        mCnt;
  bit [WORD_W-1:0] mOut;

  function automatic bit [WORD_W-1:0] pat(input int a);
    bit [7:0] b = 8'(a);
    return {b, 1'b1, b ^ 8'h5A, 1'b0, b + 8'd3, 1'b1, ~b, 1'b0};
  endfunction

  function automatic bit [ADDR_W-1:0] burstAddr(input bit [ADDR_W-1:0] base,
                                                input bit [1:0] cnt, input bit lin);
    bit [1:0] lo = lin ? base[1:0] + cnt : base[1:0] ^ cnt;
    return {base[ADDR_W-1:2], lo};
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic modelEdge();
    bit load, sel, acc;
    bit [1:0] cnt;
    bit [ADDR_W-1:0] base, a;
    bit [LANES-1:0] mask;
    if (!rstN) begin
      mActive = 0; mCnt = 0; mBase = 0; mPend = 0; mValid = 0; mDesel = 0;
      return;
    end
    if (mPend) mOut = mMem[mPendAddr];
    mValid = mPend;
    load = !procLoadN || !ctrlLoadN;
    sel  = !ce1N && ce2 && !ce3N;
    if (sleep) begin
      mActive = 0; mPend = 0; mDesel = 0;
      return;
    end
    acc  = load ? sel : mActive;
    cnt  = load ? 2'd0 : mCnt + 2'(!advanceN);
    base = load ? addrIn : mBase;
    a    = burstAddr(base, cnt, seqLinear);
    mask = !globalWrN ? 4'hF : (!byteWrN ? ~laneSelN : 4'h0);
    if (!procLoadN) mask = 4'h0;
    if (acc) begin
      for (int g = 0; g < LANES; g++)
        if (mask[g]) mMem[a][g*LANE_W +: LANE_W] = dataIn[g*LANE_W +: LANE_W];
    end
    mPend = acc && (mask == 4'h0);
    if (mPend) mPendAddr = a;
    mDesel = load && !sel;
    if (load) begin
      mActive = sel; mBase = addrIn; mCnt = 0;
    end else if (mActive) begin
      mCnt = cnt;
    end
  endtask

  task automatic step(input string tag);
    bit expOe;
    modelEdge();
    @(posedge clk);
    @(negedge clk);
    expOe = !oeN && !sleep && mValid && !mDesel;
    check({tag, " R13 drive"}, 64'(dataOe), 64'(expOe));
    if (expOe) check({tag, " R2 word"}, 64'(dataOut), 64'(mOut));
  endtask

  task automatic idle();
    procLoadN = 1; ctrlLoadN = 1; advanceN = 1; globalWrN = 1; byteWrN = 1;
    laneSelN = 4'hF; ce1N = 0; ce2 = 1; ce3N = 0; sleep = 0;
  endtask

  task automatic procRead(input int a);
    idle(); procLoadN = 0; addrIn = ADDR_W'(a);
  endtask

  task automatic ctrlWrite(input int a, input bit [WORD_W-1:0] d,
                           input bit gw, input bit bw, input bit [3:0] lanes);
    idle(); ctrlLoadN = 0; addrIn = ADDR_W'(a); dataIn = d;
    globalWrN = gw; byteWrN = bw; laneSelN = lanes;
  endtask

  task automatic deselect(input string tag);
    idle(); ctrlLoadN = 0; ce2 = 0; step(tag);
  endtask

  task automatic readBack(input int a, input bit [WORD_W-1:0] exp, input string tag);
    deselect(tag);
    procRead(a); step(tag);
    idle(); step(tag);
    check({tag, " drive"}, 64'(dataOe), 64'd1);
    check({tag, " word"}, 64'(dataOut), 64'(exp));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int seed;
    bit [WORD_W-1:0] d;
    int expLin [4] = '{17, 18, 19, 16};
    int expIlv [4] = '{17, 16, 19, 18};
    seed = $urandom(32'd2468);
    idle(); rstN = 0; oeN = 0; seqLinear = 0; addrIn = '0; dataIn = '0;
    @(negedge clk);
    repeat (3) step("R12 reset");
    check("R12 reset drive", 64'(dataOe), 64'd0);
    rstN = 1;

    // R5: fill the array with all-lane writes, lane controls set against it
    for (int a = 0; a < DEPTH; a++) begin
      ctrlWrite(a, pat(a), 1'b0, 1'b1, 4'hF);
      step("R5 fill");
    end
    readBack(33, pat(33), "R5");

    // R2: data drives one edge after capture
    deselect("R2");
    procRead(5); step("R2");
    check("R2 early", 64'(dataOe), 64'd0);
    idle(); step("R2");
    check("R2 late drive", 64'(dataOe), 64'd1);
    check("R2 late word", 64'(dataOut), 64'(pat(5)));

    // R3: deselect right after a read removes drive at once
    procRead(7); step("R3");
    deselect("R3");
    check("R3 off", 64'(dataOe), 64'd0);

    // R4: lanes 0 and 2 written only
    d = 36'hA_BCDE_F123;
    ctrlWrite(9, d, 1'b1, 1'b0, 4'b1010); step("R4");
    readBack(9, {pat(9)[35:27], d[26:18], pat(9)[17:9], d[8:0]}, "R4");

    // R6: no write enable active
    deselect("R6");
    ctrlWrite(10, ~pat(10), 1'b1, 1'b1, 4'h0); step("R6");
    idle(); step("R6");
    check("R6 word", 64'(dataOut), 64'(pat(10)));

    // R7: read strobe ignores write controls
    deselect("R7");
    idle(); procLoadN = 0; addrIn = 11; dataIn = ~pat(11); globalWrN = 0;
    byteWrN = 0; laneSelN = 4'h0; step("R7");
    idle(); step("R7");
    check("R7 word", 64'(dataOut), 64'(pat(11)));
    readBack(11, pat(11), "R7 kept");

    // R1: write with one enable inactive stores nothing
    ctrlWrite(12, ~pat(12), 1'b0, 1'b1, 4'hF); ce3N = 1; step("R1");
    check("R1 no drive", 64'(dataOe), 64'd0);
    ctrlWrite(14, ~pat(14), 1'b0, 1'b1, 4'hF); ce1N = 1; step("R1");
    readBack(12, pat(12), "R1 ce3N");
    readBack(14, pat(14), "R1 ce1N");

    // R8: burst orders
    for (int m = 0; m < 2; m++) begin
      deselect("R8");
      seqLinear = (m == 0);
      procRead(17); step("R8");
      idle(); advanceN = 0;
      for (int k = 0; k < 4; k++) begin
        step("R8");
        check("R8 beat", 64'(dataOut),
              64'(pat(m == 0 ? expLin[k] : expIlv[k])));
      end
    end
    seqLinear = 0;

    // R9: suspend repeats the address
    deselect("R9");
    procRead(20); step("R9");
    idle(); step("R9");
    step("R9");
    check("R9 hold", 64'(dataOut), 64'(pat(20)));
    advanceN = 0; step("R9");
    step("R9");
    check("R9 step", 64'(dataOut), 64'(pat(21)));

    // R10: asynchronous output enable
    deselect("R10");
    procRead(22); step("R10");
    idle(); step("R10");
    #0.5 oeN = 1;
    #0.3 check("R10 off", 64'(dataOe), 64'd0);
    oeN = 0;
    #0.3 check("R10 on", 64'(dataOe), 64'd1);
    @(negedge clk);

    // R11: sleep is asynchronous, blocks writes, ends burst
    #0.5 sleep = 1;
    #0.3 check("R11 async off", 64'(dataOe), 64'd0);
    @(negedge clk);
    ctrlWrite(13, ~pat(13), 1'b0, 1'b1, 4'hF); sleep = 1; step("R11");
    idle(); step("R11");
    step("R11");
    check("R11 burst ended", 64'(dataOe), 64'd0);
    readBack(13, pat(13), "R11 kept");

    // R12: reset during active read
    deselect("R12");
    procRead(3); step("R12");
    idle(); rstN = 0; step("R12");
    check("R12 mid reset", 64'(dataOe), 64'd0);
    rstN = 1; step("R12");

    // random mix
    for (int n = 0; n < 4000; n++) begin
      ce1N      = ($urandom % 10) == 0;
      ce2       = ($urandom % 10) != 0;
      ce3N      = ($urandom % 10) == 0;
      procLoadN = ($urandom % 4) != 0;
      ctrlLoadN = ($urandom % 3) != 0;
      advanceN  = $urandom % 2;
      seqLinear = $urandom % 2;
      globalWrN = ($urandom % 5) != 0;
      byteWrN   = $urandom % 2;
      laneSelN  = 4'($urandom);
      oeN       = ($urandom % 6) == 0;
      sleep     = ($urandom % 20) == 0;
      addrIn    = ADDR_W'($urandom);
      dataIn    = {4'($urandom), 32'($urandom)};
      step("R13 random");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule